// File: doc/BRIEF.md
# Debug Halt Control Unit

This block sits between a debug probe and a processor core. The probe reaches it over a simple 32-bit word-addressed register bus. It holds four registers: a halt control/status word, a debug fault flag word, a core-register selector and a 32-bit transfer data word. From these it drives halt, single-step and interrupt-mask requests to the core. It records why the core stopped: a halt request, a finished step, a breakpoint, a watchpoint, a vector catch or an external request.

Core registers move through a fixed-latency handshake. The probe loads the data word, then writes the selector with an index and a direction. It waits for the ready flag, then reads the data word if the transfer was a read. The core register file sits inside the block. It holds the sixteen general registers plus the program status, main stack and process stack pointers.

Register offsets (word index on `bus_addr_i`): 0 control/status, 1 fault flags, 2 selector, 3 transfer data.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A write to offset 0 changes the control bits only when bits 31:16 hold 16'hA05F. Any other upper value leaves every control bit and the core outputs unchanged.
- R2: Control bits read back at offset 0 as: debug enable bit 0, halt request bit 1, step bit 2, interrupt mask bit 3, snapshot stall bit 5. `core_step_o` is debug enable AND step, and `core_mask_irq_o` is debug enable AND interrupt mask.
- R3: A keyed write with debug enable and halt set raises `core_halt_o` one cycle after the write edge. The halted state reads back at offset 0 bit 17. `core_halt_o` is never high while debug enable is 0.
- R4: A keyed write with halt clear releases the core at the write edge. If step is set, the first `core_retire_i` pulse halts the core again at the next edge and sets the fault flag at bit 0.
- R5: A keyed write with debug enable 0 clears the halt and step requests and drops `core_halt_o`.
- R6: Offset 0 bit 25 is set while `core_reset_i` is high and stays set until offset 0 is read; that read returns 1 and clears it. Bit 24 behaves the same way for `core_retire_i`. Bit 18 mirrors `core_sleep_i` and bit 19 mirrors `core_lockup_i`.
- R7: Fault flags at offset 1 are: bit 0 halted by request or step, bit 1 breakpoint, bit 2 watchpoint, bit 3 vector catch, bit 4 external. Each event input sets its flag and halts the core only while debug enable is 1, and has no effect otherwise.
- R8: Writing offset 1 clears exactly those flags whose written bit is 1. A zero bit has no effect.
- R9: Ready (offset 0 bit 16) is 1 out of reset. It goes to 0 at the edge that writes the selector and returns to 1 two cycles later.
- R10: The selector holds the register index in bits 4:0 and the write-not-read flag in bit 16. With bit 16 set, the transfer copies the data word into the indexed core register. With bit 16 clear, it copies the indexed core register into the data word. Index 0x0F is the PC, 0x10 the status word, 0x11 the main stack pointer and 0x12 the process stack pointer.
- R11: Indices 0x13 to 0x1F address no register: a write transfer to them changes nothing and a read transfer returns 0.
- R12: A bus read returns its data with `bus_rvalid_o` high in the cycle after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 2 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid |
| core_retire_i | input | 1 | Core retired an instruction |
| core_sleep_i | input | 1 | Core is sleeping |
| core_lockup_i | input | 1 | Core is locked up |
| core_reset_i | input | 1 | Core is in reset |
| bkpt_evt_i | input | 1 | Breakpoint hit |
| dwt_evt_i | input | 1 | Watchpoint hit |
| vcatch_evt_i | input | 1 | Vector catch hit |
| ext_evt_i | input | 1 | External halt request |
| core_halt_o | output | 1 | Core must stay stopped |
| core_step_o | output | 1 | Single-step requested |
| core_mask_irq_o | output | 1 | Mask interrupts in the core |

## Verification
The bench writes the control word with wrong keys. A design that compared fewer key bits, or that loaded the low bits anyway, would show changed control bits or a halted core. It steps a halted core and checks that one retire pulse re-halts it and sets the halted flag; a design that ignored the step would leave the core running. Events are fired with debug disabled, where a careless design would set flags or halt. Fault flags are cleared one at a time to catch a write that clears everything. The ready flag is sampled at each cycle after a selector write to expose an off-by-one latency. Random transfers over all 32 indices, including the unmapped ones, catch swapped directions and writes that alias into real registers.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int          DATA_W    = 32;
  localparam int          IDX_W     = 5;
  localparam logic [15:0] CTRL_KEY  = 16'hA05F;
  localparam int          NUM_EVT   = 4;
  localparam int          FAULT_W   = NUM_EVT + 1;

  localparam int REG_CTRL  = 0;
  localparam int REG_FAULT = 1;
  localparam int REG_SEL   = 2;
  localparam int REG_DATA  = 3;

  // status bit positions in the control/status word
  localparam int ST_RDY    = 16;
  localparam int ST_HALT   = 17;
  localparam int ST_SLEEP  = 18;
  localparam int ST_LOCK   = 19;
  localparam int ST_RETIRE = 24;
  localparam int ST_RESET  = 25;
  localparam int SEL_WNR   = 16;

  typedef struct packed {
    logic snapstall;
    logic maskints;
    logic step;
    logic halt;
    logic debugen;
  } ctrl_t;
endpackage

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_load_i,
  input  ctrl_t              ctrl_new_i,
  input  logic [FAULT_W-1:0] fault_clr_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               retire_i,
  output ctrl_t              ctrl_o,
  output logic               halted_o,
  output logic [FAULT_W-1:0] fault_o
);
  ctrl_t              ctrl_q;
  logic               halted_q;
  logic [FAULT_W-1:0] fault_q;
  logic [FAULT_W-1:0] fault_set;
  logic               req_halt, step_done, evt_hit, release_w;

  assign req_halt  = ctrl_q.debugen & ctrl_q.halt & ~halted_q;
  assign step_done = ctrl_q.debugen & ctrl_q.step & ~ctrl_q.halt & ~halted_q & retire_i;
  assign evt_hit   = ctrl_q.debugen & (|evt_i);
  assign release_w = ctrl_load_i & ~(ctrl_new_i.debugen & ctrl_new_i.halt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_load_i) begin
      ctrl_q.debugen   <= ctrl_new_i.debugen;
      ctrl_q.halt      <= ctrl_new_i.halt & ctrl_new_i.debugen;
      ctrl_q.step      <= ctrl_new_i.step & ctrl_new_i.debugen;
      ctrl_q.maskints  <= ctrl_new_i.maskints;
      ctrl_q.snapstall <= ctrl_new_i.snapstall;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              halted_q <= 1'b0;
    else if (release_w)                       halted_q <= 1'b0;
    else if (req_halt | step_done | evt_hit)  halted_q <= 1'b1;
  end

  assign fault_set[0] = req_halt | step_done;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    assign fault_set[k+1] = ctrl_q.debugen & evt_i[k];
  end

  // set wins over a same-cycle clear
  for (genvar f = 0; f < FAULT_W; f++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           fault_q[f] <= 1'b0;
      else if (fault_set[f]) fault_q[f] <= 1'b1;
      else if (fault_clr_i[f]) fault_q[f] <= 1'b0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign halted_o = halted_q;
  assign fault_o  = fault_q;
endmodule

// File: rtl/dbg_core_regs.sv
module dbg_core_regs
  import dbg_pkg::*;
#(
  parameter int NUM_REGS = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[i] <= '0;
      else if (we_i && idx_i == IDX_W'(i))       mem_q[i] <= wdata_i;
    end
  end

  // unmapped indices read as zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_i == IDX_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/dbg_xfer.sv
module dbg_xfer
  import dbg_pkg::*;
#(
  parameter int XFER_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_wr_i,
  input  logic [IDX_W-1:0]  sel_idx_i,
  input  logic              sel_wnr_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] creg_rdata_i,
  output logic [IDX_W-1:0]  sel_idx_o,
  output logic              sel_wnr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              creg_we_o
);
  localparam int CNT_W = $clog2(XFER_LAT + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              wnr_q;
  logic [DATA_W-1:0] data_q;
  logic              done;

  assign done = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      wnr_q <= 1'b0;
    end else if (sel_wr_i) begin
      cnt_q <= CNT_W'(XFER_LAT);
      idx_q <= sel_idx_i;
      wnr_q <= sel_wnr_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              data_q <= '0;
    else if (done && !wnr_q)  data_q <= creg_rdata_i;
    else if (data_wr_i)       data_q <= wdata_i;
  end

  assign creg_we_o = done & wnr_q;
  assign sel_idx_o = idx_q;
  assign sel_wnr_o = wnr_q;
  assign data_o    = data_q;
  assign rdy_o     = (cnt_q == '0);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int NUM_CREGS = 19,
  parameter int XFER_LAT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic              core_retire_i,
  input  logic              core_sleep_i,
  input  logic              core_lockup_i,
  input  logic              core_reset_i,
  input  logic              bkpt_evt_i,
  input  logic              dwt_evt_i,
  input  logic              vcatch_evt_i,
  input  logic              ext_evt_i,
  output logic              core_halt_o,
  output logic              core_step_o,
  output logic              core_mask_irq_o
);
  logic               wr, rd, ctrl_wr, ctrl_rd, fault_wr, sel_wr, data_wr, ctrl_load;
  ctrl_t              ctrl_new, ctrl_q;
  logic               halted;
  logic [FAULT_W-1:0] fault_q, fault_clr;
  logic [IDX_W-1:0]   sel_idx;
  logic               sel_wnr, regrdy, creg_we;
  logic [DATA_W-1:0]  xfer_data, creg_rdata;
  logic               reset_st_q, retire_st_q;
  logic [31:0]        status_w, rd_mux, rdata_q;
  logic               rvalid_q;

  assign wr       = bus_req_i & bus_we_i;
  assign rd       = bus_req_i & ~bus_we_i;
  assign ctrl_wr  = wr && (bus_addr_i == ADDR_W'(REG_CTRL));
  assign ctrl_rd  = rd && (bus_addr_i == ADDR_W'(REG_CTRL));
  assign fault_wr = wr && (bus_addr_i == ADDR_W'(REG_FAULT));
  assign sel_wr   = wr && (bus_addr_i == ADDR_W'(REG_SEL));
  assign data_wr  = wr && (bus_addr_i == ADDR_W'(REG_DATA));

  assign ctrl_load = ctrl_wr && (bus_wdata_i[31:16] == CTRL_KEY);
  assign ctrl_new  = '{snapstall: bus_wdata_i[5], maskints: bus_wdata_i[3],
                       step: bus_wdata_i[2], halt: bus_wdata_i[1],
                       debugen: bus_wdata_i[0]};
  assign fault_clr = fault_wr ? bus_wdata_i[FAULT_W-1:0] : '0;

  dbg_run_ctrl u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_load_i (ctrl_load),
    .ctrl_new_i  (ctrl_new),
    .fault_clr_i (fault_clr),
    .evt_i       ({ext_evt_i, vcatch_evt_i, dwt_evt_i, bkpt_evt_i}),
    .retire_i    (core_retire_i),
    .ctrl_o      (ctrl_q),
    .halted_o    (halted),
    .fault_o     (fault_q)
  );

  dbg_xfer #(.XFER_LAT(XFER_LAT)) u_xfer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_wr_i     (sel_wr),
    .sel_idx_i    (bus_wdata_i[IDX_W-1:0]),
    .sel_wnr_i    (bus_wdata_i[SEL_WNR]),
    .data_wr_i    (data_wr),
    .wdata_i      (bus_wdata_i),
    .creg_rdata_i (creg_rdata),
    .sel_idx_o    (sel_idx),
    .sel_wnr_o    (sel_wnr),
    .data_o       (xfer_data),
    .rdy_o        (regrdy),
    .creg_we_o    (creg_we)
  );

  dbg_core_regs #(.NUM_REGS(NUM_CREGS)) u_cregs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (creg_we),
    .idx_i   (sel_idx),
    .wdata_i (xfer_data),
    .rdata_o (creg_rdata)
  );

  // sticky status: set by the core, cleared by a status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reset_st_q  <= 1'b0;
      retire_st_q <= 1'b0;
    end else begin
      if (core_reset_i)       reset_st_q <= 1'b1;
      else if (ctrl_rd)       reset_st_q <= 1'b0;
      if (core_retire_i)      retire_st_q <= 1'b1;
      else if (ctrl_rd)       retire_st_q <= 1'b0;
    end
  end

  always_comb begin
    status_w            = '0;
    status_w[0]         = ctrl_q.debugen;
    status_w[1]         = ctrl_q.halt;
    status_w[2]         = ctrl_q.step;
    status_w[3]         = ctrl_q.maskints;
    status_w[5]         = ctrl_q.snapstall;
    status_w[ST_RDY]    = regrdy;
    status_w[ST_HALT]   = halted;
    status_w[ST_SLEEP]  = core_sleep_i;
    status_w[ST_LOCK]   = core_lockup_i;
    status_w[ST_RETIRE] = retire_st_q;
    status_w[ST_RESET]  = reset_st_q;
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_W'(REG_CTRL):  rd_mux = status_w;
      ADDR_W'(REG_FAULT): rd_mux = 32'(fault_q);
      ADDR_W'(REG_SEL):   rd_mux = {15'b0, sel_wnr, 11'b0, sel_idx};
      ADDR_W'(REG_DATA):  rd_mux = xfer_data;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata_o     = rdata_q;
  assign bus_rvalid_o    = rvalid_q;
  assign core_halt_o     = halted;
  assign core_step_o     = ctrl_q.debugen & ctrl_q.step;
  assign core_mask_irq_o = ctrl_q.debugen & ctrl_q.maskints;
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk
  import dbg_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              bus_rvalid_o,
  input logic              core_retire_i,
  input logic              core_reset_i,
  input logic              core_halt_o,
  input logic              core_step_o,
  input ctrl_t             ctrl_q,
  input logic              ctrl_load,
  input logic [FAULT_W-1:0] fault_q,
  input logic              regrdy,
  input logic              reset_st_q
);
  logic ctrl_wr_nokey, fault_wr, sel_wr, rd;
  assign ctrl_wr_nokey = bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(REG_CTRL)
                         && bus_wdata_i[31:16] != CTRL_KEY;
  assign fault_wr = bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(REG_FAULT);
  assign sel_wr   = bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(REG_SEL);
  assign rd       = bus_req_i && !bus_we_i;

  p_nokey_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_nokey |=> $stable(ctrl_q));

  p_halt_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_halt_o |-> ctrl_q.debugen);

  p_step_rehalt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_halt_o && core_step_o && core_retire_i && !ctrl_load) |=> core_halt_o);

  p_reset_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_reset_i |=> reset_st_q);

  p_flags_grow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_wr |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

  p_rdy_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> !regrdy);

  p_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> bus_rvalid_o);

  p_no_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !bus_rvalid_o);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_req_i     (bus_req_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rvalid_o  (bus_rvalid_o),
  .core_retire_i (core_retire_i),
  .core_reset_i  (core_reset_i),
  .core_halt_o   (core_halt_o),
  .core_step_o   (core_step_o),
  .ctrl_q        (ctrl_q),
  .ctrl_load     (ctrl_load),
  .fault_q       (fault_q),
  .regrdy        (regrdy),
  .reset_st_q    (reset_st_q)
);

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;
  localparam logic [31:0] KEY = 32'hA05F_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        retire = 0, sleep = 0, lockup = 0, creset = 0;
  logic        bkpt = 0, dwt = 0, vcatch = 0, ext = 0;
  logic        halt_o, step_o, mask_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model [32];
  logic [31:0] rv;

  always #2 clk = ~clk;

  dbg_halt_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .core_retire_i(retire), .core_sleep_i(sleep), .core_lockup_i(lockup),
    .core_reset_i(creset), .bkpt_evt_i(bkpt), .dwt_evt_i(dwt), .vcatch_evt_i(vcatch),
    .ext_evt_i(ext), .core_halt_o(halt_o), .core_step_o(step_o), .core_mask_irq_o(mask_o));

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    check("R12 rvalid", 32'(rvalid), 32'd1);
    d = rdata;
  endtask

  task automatic xfer_write(logic [4:0] idx, logic [31:0] v);
    bus_write(2'd3, v);
    bus_write(2'd2, 32'h0001_0000 | 32'(idx));
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer_read(logic [4:0] idx, output logic [31:0] v);
    bus_write(2'd2, 32'(idx));
    repeat (3) @(negedge clk);
    bus_read(2'd3, v);
  endtask

  function automatic logic [31:0] ctrl_img(logic [31:0] w);
    logic den = w[0];
    return {26'b0, w[5], 1'b0, w[3], w[2] & den, w[1] & den, den};
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog expired actual=%h expected=%h", 0, 1);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    void'($urandom(32'h0000_5eed));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    bus_read(2'd0, rv); check("R2 reset ctrl", rv, 32'h0001_0000);
    bus_read(2'd1, rv); check("R7 reset fault", rv, 0);
    check("R3 reset halt", 32'(halt_o), 0);

    // wrong key
    bus_write(2'd0, 32'h1234_0003);
    @(negedge clk);
    check("R1 nokey halt", 32'(halt_o), 0);
    bus_read(2'd0, rv); check("R1 nokey ctrl", rv & 32'h2F, 0);
    bus_write(2'd0, 32'hA05E_000F);
    bus_read(2'd0, rv); check("R1 near key", rv & 32'h2F, 0);

    // halt request
    bus_write(2'd0, KEY | 32'h3);
    check("R3 halt not yet", 32'(halt_o), 0);
    @(negedge clk);
    check("R3 halt raised", 32'(halt_o), 1);
    bus_read(2'd0, rv); check("R3 status", rv, 32'h0003_0003);
    bus_read(2'd1, rv); check("R7 halted flag", rv, 32'h1);

    // write-one-to-clear
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, rv); check("R8 zero write", rv, 32'h1);
    bus_write(2'd1, 32'h1);
    bus_read(2'd1, rv); check("R8 clear", rv, 32'h0);

    // single step
    bus_write(2'd0, KEY | 32'hD);
    check("R4 released", 32'(halt_o), 0);
    check("R2 step out", 32'(step_o), 1);
    check("R2 mask out", 32'(mask_o), 1);
    repeat (3) @(negedge clk);
    check("R4 running", 32'(halt_o), 0);
    retire = 1; @(negedge clk); retire = 0;
    check("R4 rehalted", 32'(halt_o), 1);
    bus_read(2'd1, rv); check("R4 halted flag", rv, 32'h1);
    bus_read(2'd0, rv); check("R6 retire sticky", rv, 32'h0103_000D);
    bus_read(2'd0, rv); check("R6 retire cleared", rv, 32'h0003_000D);
    bus_write(2'd1, 32'h1F);

    // disable
    bus_write(2'd0, KEY);
    check("R5 halt drop", 32'(halt_o), 0);
    check("R5 step drop", 32'(step_o), 0);
    bus_read(2'd0, rv); check("R5 ctrl", rv, 32'h0001_0000);

    // events
    bkpt = 1; @(negedge clk); bkpt = 0;
    @(negedge clk);
    check("R7 ignored halt", 32'(halt_o), 0);
    bus_read(2'd1, rv); check("R7 ignored flag", rv, 0);
    bus_write(2'd0, KEY | 32'h1);
    dwt = 1; @(negedge clk); dwt = 0;
    check("R7 dwt halt", 32'(halt_o), 1);
    bus_read(2'd1, rv); check("R7 dwt flag", rv, 32'h4);
    bus_write(2'd1, 32'h4);
    vcatch = 1; @(negedge clk); vcatch = 0;
    bus_read(2'd1, rv); check("R7 vcatch flag", rv, 32'h8);
    ext = 1; @(negedge clk); ext = 0;
    bus_read(2'd1, rv); check("R7 ext flag", rv, 32'h18);
    bkpt = 1; @(negedge clk); bkpt = 0;
    bus_read(2'd1, rv); check("R7 bkpt flag", rv, 32'h1A);
    bus_write(2'd1, 32'h10);
    bus_read(2'd1, rv); check("R8 single clear", rv, 32'hA);
    bus_write(2'd0, KEY | 32'h1);
    check("R4 release", 32'(halt_o), 0);
    bus_write(2'd1, 32'h1F);

    // sticky reset, live sleep/lockup
    creset = 1; repeat (3) @(negedge clk); creset = 0;
    bus_read(2'd0, rv); check("R6 reset sticky", rv & 32'h0200_0000, 32'h0200_0000);
    bus_read(2'd0, rv); check("R6 reset cleared", rv & 32'h0200_0000, 0);
    sleep = 1; lockup = 1;
    bus_read(2'd0, rv); check("R6 sleep lockup", (rv >> 18) & 3, 3);
    sleep = 0; lockup = 0;

    // transfer handshake
    bus_write(2'd3, 32'hCAFE_0001);
    bus_write(2'd2, 32'h0001_000F);
    bus_read(2'd0, rv); check("R9 rdy drop", (rv >> 16) & 1, 0);
    bus_read(2'd0, rv); check("R9 rdy busy", (rv >> 16) & 1, 0);
    bus_read(2'd0, rv); check("R9 rdy back", (rv >> 16) & 1, 1);
    model[15] = 32'hCAFE_0001;
    bus_read(2'd2, rv); check("R10 sel readback", rv, 32'h0001_000F);
    bus_write(2'd3, 32'h0);
    xfer_read(5'h0F, rv); check("R10 pc read", rv, 32'hCAFE_0001);
    xfer_write(5'h12, 32'h2000_0400); model[18] = 32'h2000_0400;
    xfer_read(5'h12, rv); check("R10 psp read", rv, 32'h2000_0400);
    xfer_write(5'h13, 32'hDEAD_BEEF);
    xfer_read(5'h13, rv); check("R11 unmapped", rv, 0);

    // random transfers
    for (int n = 0; n < 40; n++) begin
      logic [4:0]  ix = 5'($urandom);
      logic [31:0] v  = $urandom;
      xfer_write(ix, v);
      if (ix < 5'd19) model[ix] = v;
    end
    for (int i = 0; i < 32; i++) begin
      xfer_read(5'(i), rv);
      check(i < 19 ? "R10 random readback" : "R11 random unmapped", rv, model[i]);
    end

    // random control writes
    begin
      logic [31:0] img = 32'h1;
      logic        hm  = 1'b0;
      for (int n = 0; n < 30; n++) begin
        logic [31:0] w = $urandom;
        if ($urandom % 2) w[31:16] = 16'hA05F;
        if (w[31:16] == 16'hA05F) begin
          img = ctrl_img(w);
          hm  = img[0] & img[1];
        end
        bus_write(2'd0, w);
        bus_read(2'd0, rv);
        check(w[31:16] == 16'hA05F ? "R2 random ctrl" : "R1 random nokey", rv & 32'h2F, img);
        check("R3 random halt", 32'(halt_o), 32'(hm));
        check("R2 random step", 32'(step_o), 32'(img[0] & img[2]));
        check("R2 random mask", 32'(mask_o), 32'(img[0] & img[3]));
      end
    end

    done = 1;
    summary();
  end
endmodule